// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block computes one of four operations on two equal-width unsigned operands: bitwise AND, bitwise OR, addition, or two's-complement subtraction. The datapath is a chain of identical one-bit slices. Each slice holds its own AND and OR gates, a full adder whose B input can be inverted, and a small multiplexer tree that picks the slice result. The carry ripples from the lowest slice to the highest, and only the carry leaving the top slice is brought out. The result and that carry are captured in output registers, so they appear one clock after the inputs.

The upper select bit does two jobs at once. It chooses the inverted B input for every adder, and it drives the carry into the lowest slice. Nothing decodes it into a subtract-only signal. The adder therefore always computes A + ~B + 1 whenever the upper select bit is 1, and the OR operation shows that carry too. Users read the carry only after add and subtract. During AND and OR its value is defined, but it has no meaning.

Top module: `alu_slice_chain`

## Requirements
- R1: With op_sel = 2'b00 the result is opnd_a AND opnd_b, bit by bit.
- R2: With op_sel = 2'b01 the result is (opnd_a + opnd_b) modulo 2^WIDTH.
- R3: With op_sel = 2'b10 the result is opnd_a OR opnd_b, bit by bit.
- R4: With op_sel = 2'b11 the result is (opnd_a - opnd_b) modulo 2^WIDTH, formed as opnd_a + ~opnd_b + 1.
- R5: For op_sel = 2'b01, carry_out is bit WIDTH of the unsigned sum opnd_a + opnd_b.
- R6: For op_sel = 2'b11, carry_out is 1 exactly when opnd_a >= opnd_b unsigned, meaning no borrow. It is 0 when a borrow occurs.
- R7: Only op_sel[1] controls both the B inversion and the carry into slice 0. During OR, carry_out equals the subtract carry (opnd_a >= opnd_b). During AND, it equals the add carry.
- R8: The result and carry_out are registered. They show the inputs sampled at the previous rising edge of clk, and they do not change between edges.
- R9: A synchronous active-high rst clears the result and carry_out to 0 at the next rising edge, whatever the inputs are.
- R10: With WIDTH = 8 the block gives these results:
  - 0x1F AND 0x01 = 0x01
  - 0x1F + 0x01 = 0x20
  - 0x1F OR 0x01 = 0x1F
  - 0x1F - 0x01 = 0x1E, with carry_out 1
  - 0x88 + 0x11 = 0x99

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 2 | Operation: 00 AND, 01 add, 10 OR, 11 subtract |
| result | output | WIDTH | Registered operation result |
| carry_out | output | 1 | Registered carry leaving the top slice |

## Verification
On every cycle out of reset, assertions in the top module compare the registered result and carry with the operands and select from the cycle before. They cover all four operations, including the carry that the shared control produces during AND and OR. The bench scenarios are the only way to show three things:
- the synchronous clear, which assertions are disabled for;
- the one-cycle latency, where the output holds until the edge;
- the listed example vectors and the subtract boundaries (equal operands, zero minus nonzero, all-ones operands).

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Select encoding; the ALU slices use op_sel[1] and op_sel[0] directly.
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_ADD = 2'b01,
    OP_OR  = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;

endpackage

// File: rtl/alu_mux2.sv
module alu_mux2 #(
  parameter int W = 1
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic         sel,
  output logic [W-1:0] out
);

  always_comb begin
    out = sel ? in1 : in0;
  end

endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic p;

  always_comb begin
    p  = x ^ y;
    s  = p ^ ci;
    co = (x & y) | (p & ci);
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic bit_a,
  input  logic bit_b,
  input  logic sel_lo,
  input  logic sel_hi,
  input  logic c_in,
  output logic bit_res,
  output logic c_out
);

  logic b_inv;
  logic b_eff;
  logic and_bit;
  logic or_bit;
  logic sum_bit;
  logic pick_lo;
  logic pick_hi;

  always_comb begin
    b_inv   = ~bit_b;
    and_bit = bit_a & bit_b;
    or_bit  = bit_a | bit_b;
  end

  // sel_hi alone picks the inverted B for every slice (shared with carry-in).
  alu_mux2 #(.W(1)) u_bsel (
    .in0 (bit_b),
    .in1 (b_inv),
    .sel (sel_hi),
    .out (b_eff)
  );

  alu_full_adder u_fa (
    .x  (bit_a),
    .y  (b_eff),
    .ci (c_in),
    .s  (sum_bit),
    .co (c_out)
  );

  // sel_lo: logic op vs adder, in each half; sel_hi: which half.
  alu_mux2 #(.W(1)) u_mlo (
    .in0 (and_bit),
    .in1 (sum_bit),
    .sel (sel_lo),
    .out (pick_lo)
  );

  alu_mux2 #(.W(1)) u_mhi (
    .in0 (or_bit),
    .in1 (sum_bit),
    .sel (sel_lo),
    .out (pick_hi)
  );

  alu_mux2 #(.W(1)) u_mout (
    .in0 (pick_lo),
    .in1 (pick_hi),
    .sel (sel_hi),
    .out (bit_res)
  );

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry_chain;
  logic [WIDTH-1:0]  slice_res;

  // Carry into slice 0 is the raw upper select bit (R7).
  assign carry_chain[0] = op_sel[1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .bit_a   (opnd_a[i]),
      .bit_b   (opnd_b[i]),
      .sel_lo  (op_sel[0]),
      .sel_hi  (op_sel[1]),
      .c_in    (carry_chain[i]),
      .bit_res (slice_res[i]),
      .c_out   (carry_chain[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= slice_res;
      carry_out <= carry_chain[WIDTH];
    end
  end

  // R1
  a_r1_and_result: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_AND) |=> (result == ($past(opnd_a) & $past(opnd_b))));

  // R2
  a_r2_add_result: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD) |=> (result == $past(opnd_a) + $past(opnd_b)));

  // R3
  a_r3_or_result: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_OR) |=> (result == ($past(opnd_a) | $past(opnd_b))));

  // R4
  a_r4_sub_result: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB) |=> (result == $past(opnd_a) - $past(opnd_b)));

  // R5: a + b overflows exactly when a > ~b
  a_r5_add_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD) |=> (carry_out == ($past(opnd_a) > ~$past(opnd_b))));

  // R6
  a_r6_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB) |=> (carry_out == ($past(opnd_a) >= $past(opnd_b))));

  // R7: shared control makes logic ops carry like their adder sibling
  a_r7_or_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_OR) |=> (carry_out == ($past(opnd_a) >= $past(opnd_b))));

  a_r7_and_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_AND) |=> (carry_out == ($past(opnd_a) > ~$past(opnd_b))));

endmodule

// File: tb/alu_slice_chain_bench.sv
`timescale 1ns/1ps
module alu_slice_chain_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alu_slice_chain #(.WIDTH(W)) u_alu_slice_chain (
    .clk       (clk),
    .rst       (rst),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out)
  );

  function automatic logic [W-1:0] ref_res(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    case (f)
      2'b00:   return a & b;
      2'b01:   return W'((W+1)'(a) + (W+1)'(b));
      2'b10:   return a | b;
      default: return W'((W+1)'(a) + (W+1)'(~b) + (W+1)'(1));
    endcase
  endfunction

  function automatic logic ref_carry(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    logic [W:0] s;
    if (f[1]) return (a >= b);
    s = {1'b0, a} + {1'b0, b};
    return s[W];
  endfunction

  task automatic check_val(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at a falling edge; check at the next falling edge (one register).
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f,
                       string req, bit chk_carry);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = f;
    @(negedge clk);
    check_val(req, result, ref_res(a, b, f));
    if (chk_carry) check_val(req, {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, ref_carry(a, b, f)});
  endtask

  task automatic t_reset();
    // R9: clear under nonzero inputs
    rst = 1'b1;
    @(negedge clk);
    opnd_a = 8'hFF; opnd_b = 8'h01; op_sel = 2'b01;
    @(negedge clk);
    check_val("R9 reset result", result, '0);
    check_val("R9 reset carry", {7'b0, carry_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    check_val("R9 release", result, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    check_val("R9 mid-run clear", result, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_known();
    apply(8'h1F, 8'h01, 2'b00, "R10 and", 1'b0);
    apply(8'h1F, 8'h01, 2'b01, "R10 add", 1'b1);
    apply(8'h1F, 8'h01, 2'b10, "R10 or", 1'b0);
    apply(8'h1F, 8'h01, 2'b11, "R10 sub", 1'b1);
    check_val("R10 sub carry 1", {7'b0, carry_out}, 8'h01);
    apply(8'h88, 8'h11, 2'b01, "R10 add2", 1'b1);
  endtask

  task automatic t_sweep(logic [1:0] f, string req, bit chk_carry);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 18; j++) begin
        apply(W'(i), W'(j * 15 + i * 7), f, req, chk_carry);
      end
    end
  endtask

  task automatic t_sub_edges();
    apply(8'h55, 8'h55, 2'b11, "R6 equal", 1'b1);
    apply(8'h00, 8'h01, 2'b11, "R6 borrow", 1'b1);
    apply(8'h00, 8'h00, 2'b11, "R4 zero", 1'b1);
    apply(8'hFF, 8'hFF, 2'b11, "R4 ones", 1'b1);
    apply(8'h01, 8'hFF, 2'b11, "R6 borrow max", 1'b1);
    apply(8'hFF, 8'h01, 2'b01, "R5 wrap", 1'b1);
  endtask

  task automatic t_shared_carry();
    // R7: carry during logic ops follows op_sel[1]-controlled adder
    apply(8'h1F, 8'h01, 2'b10, "R7 or carry", 1'b1);
    apply(8'h01, 8'h1F, 2'b10, "R7 or no carry", 1'b1);
    apply(8'hF0, 8'h20, 2'b00, "R7 and carry", 1'b1);
    apply(8'h10, 8'h20, 2'b00, "R7 and no carry", 1'b1);
  endtask

  task automatic t_latency();
    // R8: output holds until the edge, then updates
    apply(8'h0F, 8'hF0, 2'b10, "R8 setup", 1'b0);
    @(negedge clk);
    opnd_a = 8'h03; opnd_b = 8'h05; op_sel = 2'b01;
    @(posedge clk);
    #1;
    check_val("R8 after edge", result, 8'h08);
    @(negedge clk);
    opnd_a = 8'h00; opnd_b = 8'h00; op_sel = 2'b00;
    #2;
    check_val("R8 hold", result, 8'h08);
    @(negedge clk);
    check_val("R8 next", result, 8'h00);
  endtask

  initial begin
    t_reset();
    t_known();
    t_sub_edges();
    t_shared_carry();
    t_latency();
    t_sweep(2'b00, "R1", 1'b1);
    t_sweep(2'b01, "R2 R5", 1'b1);
    t_sweep(2'b10, "R3", 1'b1);
    t_sweep(2'b11, "R4 R6", 1'b1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule